// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block is one output channel of a clock distribution tree. It runs on a fast input clock and produces a divided clock. The high time and the low time are each set separately, in whole input cycles, so one channel can give any ratio from divide-by-2 up to divide-by-32 with an uneven duty cycle. A chip-level sync input realigns every channel that listens to it. While sync is held, the channel parks at a chosen start level. After release, a programmable phase offset delays the first edge, so that channels sharing a sync can be skewed against each other by whole input cycles.

Control fields arrive as static levels from a register block. Count and start-level changes made while the divider runs are taken at the next period boundary, which keeps the output free of runt pulses.

Other control bits change the source of the output:
- A bypass bit passes the input clock straight through.
- A direct-route bit with a 2-bit source select feeds one of two upstream clocks straight to the output.
- A force bit holds the output high. It works only on a channel that ignores sync.

The divider counters sit idle whenever the output is not taken from the divider.

Top module: `clkdiv_channel`

## Requirements
- R1: In steady running, every high level of `clk_o` lasts `high_cnt_i`+1 input cycles.
- R2: In steady running, every low level of `clk_o` lasts `low_cnt_i`+1 input cycles.
- R3: While `sync_i`=1 and `nosync_i`=0, each clock edge sets the divider output to the start level (`start_high_i`: 1 = high, 0 = low) and holds the counters.
- R4: After sync is released, counting starts at the first edge that samples `sync_i`=0. The start level remains for `phase_i` + (start level's count) + 1 edges, and then normal alternation follows.
- R5: With `nosync_i`=1, the value of `sync_i` has no effect on the output.
- R6: With `force_high_i`=1, `nosync_i`=1, `bypass_i`=0 and no effective direct route, `clk_o` is 1. Force has no effect while `nosync_i`=0.
- R7: With `bypass_i`=1 and no effective direct route, `clk_o` follows `clk_i`. This holds whatever the value of force.
- R8: With `direct_i`=1, source select 2'b10 routes `vco_clk_i` to `clk_o` and 2'b00 routes `ref_clk_i`. Both take precedence over bypass. Source select 2'b01 or 2'b11 makes `direct_i` have no effect.
- R9: Changes of high count, low count or start level made while the divider runs take effect at the edge where the output returns to the start level. A phase change takes effect only at a sync release or restart.
- R10: After reset, `clk_o` is low and the divider runs as if just released with all fields zero. The output first goes high at the second edge after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast divider input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Chip-level realignment request |
| vco_clk_i | input | 1 | Upstream oscillator clock for direct routing |
| ref_clk_i | input | 1 | Upstream reference clock for direct routing |
| high_cnt_i | input | CNT_W | High time minus one, in input cycles |
| low_cnt_i | input | CNT_W | Low time minus one, in input cycles |
| phase_i | input | CNT_W | Extra start-level cycles after sync release |
| start_high_i | input | 1 | Start level (1 = high) |
| nosync_i | input | 1 | Ignore `sync_i` when 1 |
| force_high_i | input | 1 | Hold output high (only when `nosync_i`=1) |
| bypass_i | input | 1 | Pass `clk_i` straight to output |
| direct_i | input | 1 | Enable direct routing of an upstream clock |
| src_sel_i | input | 2 | Direct-route source: 10 oscillator, 00 reference, 01/11 none |
| clk_o | output | 1 | Channel output clock |

## Verification
The assertions cover four behaviours on every cycle:
- the divider parks at the start level whenever unmasked sync is sampled;
- the output is high whenever force is effective;
- a direct route copies the selected upstream clock;
- no level of the divided output outlasts the longest span the count fields allow.

The exact lengths of the high and low levels, the phase delay after release, and the deferral of mid-run changes to the period boundary depend on sequences of stimulus. Only the bench's scoreboard can show these, by comparing the output against the expected waveform cycle by cycle. The bench also checks that sync has no effect under the mask, that force has no effect without the mask, and that bypass copies the input clock, at both clock phases.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Direct-route source select encoding
    typedef enum logic [1:0] {
        SRC_REF  = 2'b00,
        SRC_NONE = 2'b01,
        SRC_VCO  = 2'b10,
        SRC_RSVD = 2'b11
    } src_sel_e;

    // Resolved output route, highest priority first: direct, bypass, force, divider
    typedef enum logic [2:0] {
        RT_DIV    = 3'd0,
        RT_FORCE  = 3'd1,
        RT_BYPASS = 3'd2,
        RT_VCO    = 3'd3,
        RT_REF    = 3'd4
    } route_e;

endpackage

// File: rtl/clkdiv_mode_dec.sv
module clkdiv_mode_dec
    import clkdiv_pkg::*;
(
    input  logic       nosync_i,
    input  logic       force_high_i,
    input  logic       bypass_i,
    input  logic       direct_i,
    input  logic [1:0] src_sel_i,
    output route_e     route_o,
    output logic       idle_o
);

    src_sel_e src;
    logic     direct_eff;

    always_comb begin
        src        = src_sel_e'(src_sel_i);
        direct_eff = direct_i && ((src == SRC_VCO) || (src == SRC_REF));
        if (direct_eff) begin
            route_o = (src == SRC_VCO) ? RT_VCO : RT_REF;
        end else if (bypass_i) begin
            route_o = RT_BYPASS;
        end else if (nosync_i && force_high_i) begin
            route_o = RT_FORCE;
        end else begin
            route_o = RT_DIV;
        end
        // counters rest whenever the output is not taken from the divider
        idle_o = (route_o != RT_DIV);
    end

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic             nosync_i,
    input  logic             idle_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic             start_high_i,
    output logic             div_o
);

    // one extra bit: phase + first level + 1 reaches 2^(CNT_W+1)-1
    localparam int CW = CNT_W + 1;

    typedef struct packed {
        logic             lvl;
        logic [CW-1:0]    cnt;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        logic             st;
    } div_state_t;

    localparam div_state_t RST_STATE = '{
        lvl: 1'b0,
        cnt: CW'(1),
        hi:  '0,
        lo:  '0,
        st:  1'b0
    };

    div_state_t       st_d, st_q;
    logic             hold;
    logic             at_zero;
    logic             at_boundary;
    logic             nxt_lvl;
    logic [CNT_W-1:0] first_len;
    logic [CNT_W-1:0] next_len;

    always_comb begin
        st_d        = st_q;
        hold        = idle_i | (sync_i & ~nosync_i);
        first_len   = start_high_i ? high_cnt_i : low_cnt_i;
        at_zero     = (st_q.cnt == '0);
        at_boundary = at_zero && (st_q.lvl != st_q.st);
        nxt_lvl     = ~st_q.lvl;
        next_len    = '0;
        if (hold) begin
            // parked: track live fields, preload the release delay
            st_d.hi  = high_cnt_i;
            st_d.lo  = low_cnt_i;
            st_d.st  = start_high_i;
            st_d.lvl = start_high_i;
            st_d.cnt = CW'(phase_i) + CW'(first_len) + CW'(1);
        end else if (at_zero) begin
            if (at_boundary) begin
                // returning to the start level: accept new counts here only
                st_d.hi = high_cnt_i;
                st_d.lo = low_cnt_i;
                st_d.st = start_high_i;
            end
            next_len = nxt_lvl ? st_d.hi : st_d.lo;
            st_d.lvl = nxt_lvl;
            st_d.cnt = CW'(next_len);
        end else begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o = st_q.lvl;

endmodule

// File: rtl/clkdiv_outmux.sv
module clkdiv_outmux
    import clkdiv_pkg::*;
(
    input  route_e route_i,
    input  logic   clk_i,
    input  logic   vco_clk_i,
    input  logic   ref_clk_i,
    input  logic   div_i,
    output logic   clk_o
);

    always_comb begin
        case (route_i)
            RT_VCO:    clk_o = vco_clk_i;
            RT_REF:    clk_o = ref_clk_i;
            RT_BYPASS: clk_o = clk_i;
            RT_FORCE:  clk_o = 1'b1;
            default:   clk_o = div_i;
        endcase
    end

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic             vco_clk_i,
    input  logic             ref_clk_i,
    input  logic [CNT_W-1:0] high_cnt_i,
    input  logic [CNT_W-1:0] low_cnt_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic             start_high_i,
    input  logic             nosync_i,
    input  logic             force_high_i,
    input  logic             bypass_i,
    input  logic             direct_i,
    input  logic [1:0]       src_sel_i,
    output logic             clk_o
);

    route_e route;
    logic   div_idle;
    logic   div_out;

    clkdiv_mode_dec i_mode_dec (
        .nosync_i     (nosync_i),
        .force_high_i (force_high_i),
        .bypass_i     (bypass_i),
        .direct_i     (direct_i),
        .src_sel_i    (src_sel_i),
        .route_o      (route),
        .idle_o       (div_idle)
    );

    clkdiv_core #(.CNT_W(CNT_W)) i_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sync_i       (sync_i),
        .nosync_i     (nosync_i),
        .idle_i       (div_idle),
        .high_cnt_i   (high_cnt_i),
        .low_cnt_i    (low_cnt_i),
        .phase_i      (phase_i),
        .start_high_i (start_high_i),
        .div_o        (div_out)
    );

    clkdiv_outmux i_outmux (
        .route_i   (route),
        .clk_i     (clk_i),
        .vco_clk_i (vco_clk_i),
        .ref_clk_i (ref_clk_i),
        .div_i     (div_out),
        .clk_o     (clk_o)
    );

endmodule

// File: rtl/clkdiv_channel_chk.sv
module clkdiv_channel_chk #(
    parameter int CNT_W = 4
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       sync_i,
    input logic       nosync_i,
    input logic       start_high_i,
    input logic       force_high_i,
    input logic       bypass_i,
    input logic       direct_i,
    input logic [1:0] src_sel_i,
    input logic       vco_clk_i,
    input logic       ref_clk_i,
    input logic       div_out,
    input logic       div_idle,
    input logic       clk_o
);

    localparam int LW  = CNT_W + 3;
    localparam int LIM = (2 ** (CNT_W + 1)) + 1;

    logic          direct_eff;
    logic          parked;
    logic          prev_q;
    logic [LW-1:0] len_q;

    assign direct_eff = direct_i && ((src_sel_i == 2'b10) || (src_sel_i == 2'b00));
    assign parked     = div_idle || (sync_i && !nosync_i);

    // length of the current divider level, in edges since it began
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            len_q  <= '0;
        end else begin
            prev_q <= div_out;
            if (parked) begin
                len_q <= '0;
            end else if (div_out != prev_q) begin
                len_q <= LW'(1);
            end else if (len_q != '1) begin
                len_q <= len_q + LW'(1);
            end
        end
    end

    // R3: unmasked sync parks the divider at the start level
    p_sync_park_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !nosync_i) |=> (div_out == $past(start_high_i)));

    // R6: effective force drives the output high
    p_force_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nosync_i && force_high_i && !bypass_i && !direct_eff) |-> clk_o);

    // R8: oscillator route copies the upstream oscillator
    p_direct_vco_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (direct_i && (src_sel_i == 2'b10)) |-> (clk_o == vco_clk_i));

    // R8: reference route copies the upstream reference
    p_direct_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (direct_i && (src_sel_i == 2'b00)) |-> (clk_o == ref_clk_i));

    // R4: no divider level outlasts phase plus the largest count
    p_level_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(len_q) <= LIM));

endmodule

bind clkdiv_channel clkdiv_channel_chk #(.CNT_W(CNT_W)) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (sync_i),
    .nosync_i     (nosync_i),
    .start_high_i (start_high_i),
    .force_high_i (force_high_i),
    .bypass_i     (bypass_i),
    .direct_i     (direct_i),
    .src_sel_i    (src_sel_i),
    .vco_clk_i    (vco_clk_i),
    .ref_clk_i    (ref_clk_i),
    .div_out      (div_out),
    .div_idle     (div_idle),
    .clk_o        (clk_o)
);

// File: tb/test_clkdiv_channel.sv
`timescale 1ns/1ps
module test_clkdiv_channel;

    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync = 1'b0;
    logic             vco = 1'b0;
    logic             refc = 1'b0;
    logic [CNT_W-1:0] hi = '0;
    logic [CNT_W-1:0] lo = '0;
    logic [CNT_W-1:0] ph = '0;
    logic             st = 1'b0;
    logic             nosync = 1'b0;
    logic             frc = 1'b0;
    logic             byp = 1'b0;
    logic             dir = 1'b0;
    logic [1:0]       sel = 2'b01;
    logic             clk_out;

    int n_checks = 0;
    int n_fail   = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    clkdiv_channel #(.CNT_W(CNT_W)) i_clkdiv_channel (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sync_i       (sync),
        .vco_clk_i    (vco),
        .ref_clk_i    (refc),
        .high_cnt_i   (hi),
        .low_cnt_i    (lo),
        .phase_i      (ph),
        .start_high_i (st),
        .nosync_i     (nosync),
        .force_high_i (frc),
        .bypass_i     (byp),
        .direct_i     (dir),
        .src_sel_i    (sel),
        .clk_o        (clk_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input logic v, input string req, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(req);
        end
    endtask

    // expected divider waveform right after a release, total values
    task automatic push_wave(input logic s, input int h, input int l, input int p,
                             input int total, input string req);
        int   left;
        int   run;
        logic lvl;
        left = total;
        lvl  = s;
        run  = p + (s ? h : l) + 1;
        while (left > 0) begin
            for (int i = 0; i < run && left > 0; i++) begin
                push(lvl, req, 1);
                left--;
            end
            lvl = ~lvl;
            run = (lvl ? h : l) + 1;
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // park with sync, check the parked level, release at a falling edge
    task automatic park_release(input logic s);
        @(negedge clk);
        sync = 1'b1;
        wait_neg(2);
        push(s, "R3 park level", 1);
        @(negedge clk);
        sync = 1'b0;
    endtask

    // monitor: compares one expected item after every rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, clk_out, e);
        end
    end

    task automatic run_tests;
        // R10: reset state and default divide-by-2
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R10 reset level", clk_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        push(1'b0, "R10", 1);
        push(1'b1, "R10", 1);
        push(1'b0, "R10", 1);
        push(1'b1, "R10", 1);
        wait_neg(4);

        // R1 R2: uneven duty starting low
        hi = 4'd2; lo = 4'd4; ph = 4'd0; st = 1'b0;
        park_release(1'b0);
        push_wave(1'b0, 2, 4, 0, 20, "R1 R2 R4");
        wait_neg(20);

        // R4: phase offset with start high
        hi = 4'd2; lo = 4'd1; ph = 4'd3; st = 1'b1;
        park_release(1'b1);
        push_wave(1'b1, 2, 1, 3, 18, "R4 R1 R2");
        wait_neg(18);

        // R9: mid-run change waits for the period boundary
        hi = 4'd1; lo = 4'd1; ph = 4'd0; st = 1'b0;
        park_release(1'b0);
        push(1'b0, "R9 old", 2);
        push(1'b1, "R9 old", 1);
        wait_neg(3);
        hi = 4'd2; lo = 4'd3; ph = 4'd7;
        push(1'b1, "R9 old tail", 1);
        push(1'b0, "R9 new low", 4);
        push(1'b1, "R9 new high", 3);
        push(1'b0, "R9 new low", 4);
        wait_neg(12);

        // R5: masked sync has no effect
        hi = 4'd0; lo = 4'd0; ph = 4'd0; st = 1'b0;
        park_release(1'b0);
        push_wave(1'b0, 0, 0, 0, 4, "R5 pre");
        wait_neg(4);
        nosync = 1'b1;
        sync   = 1'b1;
        push_wave(1'b0, 0, 0, 0, 6, "R5 sync ignored");
        wait_neg(6);
        sync = 1'b0;
        push_wave(1'b0, 0, 0, 0, 2, "R5");
        wait_neg(2);
        nosync = 1'b0;

        // R6: force without the mask has no effect
        frc = 1'b1;
        push_wave(1'b0, 0, 0, 0, 4, "R6 force ignored");
        wait_neg(4);
        // R6: force with the mask
        nosync = 1'b1;
        push(1'b1, "R6 forced high", 3);
        wait_neg(3);

        // R7: bypass overrides force
        byp = 1'b1;
        #1;
        check("R7 R6 bypass low phase", clk_out, clk);
        @(posedge clk);
        #1;
        check("R7 R6 bypass high phase", clk_out, 1'b1);
        @(negedge clk);
        frc    = 1'b0;
        nosync = 1'b0;
        #1;
        check("R7 bypass low", clk_out, 1'b0);
        @(posedge clk);
        #1;
        check("R7 bypass high", clk_out, 1'b1);

        // R8: direct routes, over bypass
        @(negedge clk);
        dir = 1'b1; sel = 2'b10; vco = 1'b1; refc = 1'b0;
        #1;
        check("R8 vco high", clk_out, 1'b1);
        vco = 1'b0; refc = 1'b1;
        #1;
        check("R8 vco low", clk_out, 1'b0);
        sel = 2'b00;
        #1;
        check("R8 ref high", clk_out, 1'b1);
        refc = 1'b0;
        #1;
        check("R8 ref low", clk_out, 1'b0);
        @(negedge clk);
        byp = 1'b0;
        sel = 2'b01;
        push_wave(1'b0, 0, 0, 0, 4, "R8 select 01 no effect");
        wait_neg(4);
        sel = 2'b11;
        push_wave(1'b0, 0, 0, 0, 4, "R8 select 11 no effect");
        wait_neg(4);
        dir = 1'b0;
        wait_neg(2);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #(4 * 200000);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired at %0t", $time);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule